// File: doc/BRIEF.md
# Self-Timed Parallel EEPROM Write Engine

This block sits behind the pins of a byte-wide nonvolatile memory and makes it look like a static RAM to a host. It turns the three active-low strobes (chip select, output enable, write enable) into read, write, output-disable and standby behaviour. A byte write is captured from the bus and then finished on its own, with no further help from the host. The host is free as soon as the write strobe is released.

After a write is captured, an internal cycle counter first erases the target byte to all ones and then programs it. The host can see the cycle in two ways. One is a drive-low enable for a shared ready/busy line. The other is status polling: any read during the cycle returns the inverse of bit 7 of the byte being written. Writes are refused while a digital supply-good input is low and for a fixed number of clocks after reset or after the supply recovers. A strobe pattern that holds output enable low, keeps select high or keeps write high cannot start a write.

The strobes are asynchronous to the system clock and pass through two-flop synchronizers. The address must stay valid for three clocks after the write pulse opens. The data must stay valid for three clocks after it closes.

Top module: `eeprom_write_engine`

## Requirements
- R1: `dout_en` is 1 exactly when `ce_n`=0, `oe_n`=0 and `we_n`=1. With no write in progress, `dout` then shows the byte stored at `addr`.
- R2: With `ce_n` low and `oe_n` high, a low pulse on `we_n` writes one byte. The address is taken when the pulse opens and the data when it closes, so an address change late in the pulse does not move the write.
- R3: With `we_n` low and `oe_n` high, a low pulse on `ce_n` writes a byte in the same way.
- R4: `rdy_pull_low` rises no more than 4 clocks after the pulse closes. It stays high for exactly ERASE_CYC+PROG_CYC clocks. When it falls, the location holds the written byte.
- R5: While a write is in progress, a read at any address returns the inverse of bit 7 of the byte being written on bit 7, and zeros on bits 6..0.
- R6: Write pulses that start while a write is in progress are ignored. They do not change the stored byte and do not extend the busy time.
- R7: If `oe_n` is low when the pulse would open, or goes low before it closes, no write starts. `rdy_pull_low` stays 0 and the location keeps its value.
- R8: No write starts while `supply_ok` is 0, or during the first POR_CYC clocks after reset or after `supply_ok` returns to 1.
- R9: A write changes only its own location. Every other location keeps its last written byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| supply_ok | input | 1 | Supply above write threshold |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address |
| din | input | DATA_W | Data bus as driven by the host |
| dout | output | DATA_W | Data the block drives onto the bus |
| dout_en | output | 1 | Bus drive enable |
| rdy_pull_low | output | 1 | Pull shared ready/busy line low |

## Verification
The hardest case to reach is a second write that arrives while a write is in progress. It must open and close entirely inside the busy window, and it must end before the first write's program step finishes. The bench places it there by issuing a second full write strobe right after the first one returns. It then confirms that the busy count equals one cycle's length and that the first byte survives. An output-enable drop in the middle of a pulse and the power-on lockout right after the supply recovers are reached the same way, with the timers shortened by parameters.

// File: rtl/eeprom_write_engine.sv
module eeprom_write_engine #(
  parameter int ADDR_W    = 11,
  parameter int DATA_W    = 8,
  parameter int ERASE_CYC = 300000,
  parameter int PROG_CYC  = 300000,
  parameter int POR_CYC   = 2000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              supply_ok,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  output logic              rdy_pull_low
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int TMAX  = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int TW    = $clog2(TMAX + 1);
  localparam int PW    = $clog2(POR_CYC + 1);

  typedef enum logic [1:0] {IDLE, ERASE, PROG} phase_t;

  logic [2:0]        strb_a, strb_b;
  logic [PW-1:0]     por_cnt;
  logic              por_done;
  logic              pulse_open;
  logic [ADDR_W-1:0] laddr;
  logic [DATA_W-1:0] ldata;
  phase_t            phase;
  logic [TW-1:0]     tcnt;
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      strb_a <= 3'b111;
      strb_b <= 3'b111;
    end else begin
      strb_a <= {ce_n, oe_n, we_n};
      strb_b <= strb_a;
    end

  wire ce_s    = strb_b[2];
  wire oe_s    = strb_b[1];
  wire we_s    = strb_b[0];
  wire wr_cond = !ce_s && !we_s && oe_s;
  wire busy    = (phase != IDLE);

  assign por_done = (por_cnt == PW'(POR_CYC));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          por_cnt <= '0;
    else if (!supply_ok) por_cnt <= '0;
    else if (!por_done)  por_cnt <= por_cnt + 1'b1;

  wire wr_ok = supply_ok && por_done && !busy;
  wire start = pulse_open && !wr_cond && oe_s && supply_ok && por_done;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pulse_open <= 1'b0;
      laddr      <= '0;
      ldata      <= '0;
    end else if (!pulse_open) begin
      if (wr_cond && wr_ok) begin
        pulse_open <= 1'b1;
        laddr      <= addr;
      end
    end else if (!wr_cond || !supply_ok) begin
      pulse_open <= 1'b0;
      if (start) ldata <= din;
    end

  wire erase_wr = (phase == ERASE) && (tcnt == '0);
  wire prog_wr  = (phase == PROG)  && (tcnt == '0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      phase <= IDLE;
      tcnt  <= '0;
    end else begin
      case (phase)
        IDLE: if (start) begin
          phase <= ERASE;
          tcnt  <= TW'(ERASE_CYC - 1);
        end
        ERASE: if (tcnt == '0) begin
          phase <= PROG;
          tcnt  <= TW'(PROG_CYC - 1);
        end else tcnt <= tcnt - 1'b1;
        PROG: if (tcnt == '0) phase <= IDLE;
              else tcnt <= tcnt - 1'b1;
        default: phase <= IDLE;
      endcase
    end

  always_ff @(posedge clk)
    if (erase_wr)     mem[laddr] <= '1;
    else if (prog_wr) mem[laddr] <= ldata;

  wire [DATA_W-1:0] poll_word = {~ldata[DATA_W-1], {(DATA_W-1){1'b0}}};

  assign dout_en      = !ce_n && !oe_n && we_n;
  assign dout         = !dout_en ? '0 : (busy ? poll_word : mem[addr]);
  assign rdy_pull_low = busy;

  assert_start_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(supply_ok && por_done));

  assert_pulse_before_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(pulse_open));

  assert_latch_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(ldata) && $stable(laddr)));

  assert_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (mem[laddr] == ldata));

  assert_timer_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == ERASE) |-> (tcnt < TW'(ERASE_CYC)));

  assert_no_open_while_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !pulse_open);
endmodule

// File: tb/eeprom_write_engine_test.sv
`timescale 1ns/100ps
module eeprom_write_engine_test;
  localparam int AW = 4;
  localparam int E  = 5;
  localparam int P  = 7;
  localparam int PO = 20;
  localparam int N  = 1 << AW;

  logic clk = 0, rst_n = 0, supply_ok = 1;
  logic ce_n = 1, oe_n = 1, we_n = 1;
  logic [AW-1:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic dout_en, rdy_pull_low;

  int checks = 0, failures = 0, busy_cnt = 0;
  logic [7:0] exp_mem [N];
  logic [7:0] rd_val;
  logic rd_en;

  always #2.5 clk = ~clk;

  eeprom_write_engine #(.ADDR_W(AW), .DATA_W(8), .ERASE_CYC(E), .PROG_CYC(P), .POR_CYC(PO)) uut (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .dout(dout), .dout_en(dout_en), .rdy_pull_low(rdy_pull_low));

  always @(negedge clk) if (rdy_pull_low) busy_cnt++;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d, input bit ce_ctl);
    @(posedge clk); #1;
    addr = a; din = ~d; oe_n = 1;
    if (!ce_ctl) begin ce_n = 0; @(posedge clk); #1; we_n = 0; end
    else begin we_n = 0; @(posedge clk); #1; ce_n = 0; end
    repeat (4) @(posedge clk);
    #1; addr = a ^ 4'h5; din = d;
    @(posedge clk); #1;
    if (!ce_ctl) we_n = 1; else ce_n = 1;
    repeat (4) @(posedge clk);
    #1; din = ~d; ce_n = 1; we_n = 1;
  endtask

  task automatic rd(input logic [AW-1:0] a);
    @(posedge clk); #1;
    addr = a; ce_n = 0; oe_n = 0; we_n = 1;
    #1; rd_val = dout; rd_en = dout_en;
    @(posedge clk); #1; ce_n = 1; oe_n = 1;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 80 && rdy_pull_low; i++) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #1000000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(!rdy_pull_low && !dout_en, "R1 reset state", {rdy_pull_low, dout_en}, 0);

    busy_cnt = 0;
    wr(4'd3, 8'h77, 0);
    repeat (6) @(negedge clk);
    chk(busy_cnt == 0, "R8 power-on lockout", busy_cnt, 0);
    repeat (PO + 5) @(posedge clk);

    for (int a = 0; a < N; a++) begin
      logic [7:0] d;
      d = 8'((a * 37 + 11) & 255);
      exp_mem[a] = d;
      #1 busy_cnt = 0;
      wr(4'(a), d, a[0]);
      chk(rdy_pull_low == 1, a[0] ? "R3 busy after CE pulse" : "R2 busy after WE pulse", rdy_pull_low, 1);
      rd(4'((a + 1) % N));
      chk(rd_en && rd_val == {~d[7], 7'b0}, "R5 polled read", rd_val, {~d[7], 7'b0});
      wait_idle();
      chk(busy_cnt == E + P, "R4 busy length", busy_cnt, E + P);
      rd(4'(a));
      chk(rd_val == d, "R4 committed byte", rd_val, d);
    end

    for (int a = 0; a < N; a++) begin
      rd(4'(a));
      chk(rd_en && rd_val == exp_mem[a], "R9 readback", rd_val, exp_mem[a]);
    end

    for (int c = 0; c < 8; c++) begin
      logic exp_en;
      if (c == 3'b010) continue;
      exp_en = (c == 3'b001);
      @(posedge clk); #1;
      {ce_n, oe_n, we_n} = 3'(c);
      #1 chk(dout_en == exp_en, "R1 drive enable", dout_en, exp_en);
      @(posedge clk); #1 {ce_n, oe_n, we_n} = 3'b111;
    end

    #1 busy_cnt = 0;
    wr(4'd2, 8'h5A, 0);
    wr(4'd2, 8'hA5, 1);
    wait_idle();
    chk(busy_cnt == E + P, "R6 no extra cycle", busy_cnt, E + P);
    rd(4'd2);
    chk(rd_val == 8'h5A, "R6 late write ignored", rd_val, 8'h5A);
    exp_mem[2] = 8'h5A;

    @(posedge clk); #1 busy_cnt = 0;
    addr = 4'd6; din = 8'h00; oe_n = 1; ce_n = 0; we_n = 0;
    repeat (4) @(posedge clk);
    #1 oe_n = 0;
    repeat (4) @(posedge clk);
    #1 we_n = 1; ce_n = 1;
    repeat (3) @(posedge clk);
    #1 oe_n = 1;
    repeat (6) @(negedge clk);
    chk(busy_cnt == 0, "R7 abort no busy", busy_cnt, 0);
    rd(4'd6);
    chk(rd_val == exp_mem[6], "R7 abort keeps byte", rd_val, exp_mem[6]);

    @(posedge clk); #1 busy_cnt = 0;
    addr = 4'd7; din = 8'h00; oe_n = 0; ce_n = 0; we_n = 0;
    repeat (6) @(posedge clk);
    #1 we_n = 1; ce_n = 1; oe_n = 1;
    repeat (6) @(negedge clk);
    chk(busy_cnt == 0, "R7 OE low blocks", busy_cnt, 0);

    #1 supply_ok = 0; busy_cnt = 0;
    wr(4'd5, 8'h33, 0);
    repeat (6) @(negedge clk);
    chk(busy_cnt == 0, "R8 supply low blocks", busy_cnt, 0);
    #1 supply_ok = 1;
    wr(4'd5, 8'h44, 1);
    repeat (6) @(negedge clk);
    chk(busy_cnt == 0, "R8 lockout after recovery", busy_cnt, 0);
    rd(4'd5);
    chk(rd_val == exp_mem[5], "R8 byte unchanged", rd_val, exp_mem[5]);
    repeat (PO + 5) @(posedge clk);
    #1 busy_cnt = 0;
    wr(4'd5, 8'h33, 0);
    wait_idle();
    chk(busy_cnt == E + P, "R8 write after lockout", busy_cnt, E + P);
    rd(4'd5);
    chk(rd_val == 8'h33, "R8 byte written", rd_val, 8'h33);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule